// File: doc/BRIEF.md
# Converter Protection Sequencing Controller

This block is the digital supervisor of a synchronous step-down converter. It takes comparator results that have already been reduced to single bits: the enable pin level, two supply-level flags with separate lockout and release thresholds, a low-side over-current flag, an output over-voltage flag and an over-temperature flag. It also takes a tick that marks each switching cycle. From these it decides what the gate drivers may do. They may be held fully off, forced to the low side, or handed to the PWM modulator. It also produces the reference code that the soft-start staircase feeds to the reference DAC.

After enable and supply are both good, the reference climbs one code step per prescaled interval until it reaches full scale. The converter then runs normally. Over-current is judged once per switching cycle. A single bad cycle only steers that cycle to the low side. An unbroken run of bad cycles in normal operation latches a hiccup fault. The fault holds the low side on for a number of soft-start durations and then restarts the ramp from zero. Over-voltage and over-temperature steer the drivers to the low side only while their flags are set.

Top module: `cvt_seq_ctrl`

## Requirements
- R1: `gate_mode_o` encodes 0 = both drivers off, 1 = low side forced on, 2 = PWM allowed, and never takes the value 3. While the enable level is low, `gate_mode_o` is 0 and `ss_code_o` is 0, including during reset.
- R2: Supply lockout has hysteresis and is active out of reset. It is set while `sup_low_i` is 1 and cleared only when `sup_high_i` is 1. With both flags 0 it keeps its last value. While it is set, `gate_mode_o` is 0 and `ss_code_o` is 0.
- R3: Once enable is high and lockout is clear, a soft-start begins from code 0 with `gate_mode_o` = 2. The code rises by one every PRESC clocks up to the all-ones value (2^CODE_W-1). It then stays at full scale in normal run.
- R4: During soft-start, an over-current seen at a tick sets `gate_mode_o` to 1 until the next tick. No number of such ticks ever latches a fault, and the ramp keeps advancing.
- R5: In normal run, an over-current seen at a tick sets `gate_mode_o` to 1 until the next tick. It returns to 2 at the next clean tick.
- R6: In normal run, OC_LIMIT (default 7) consecutive ticks with over-current latch a fault. A single clean tick before that count clears the count.
- R7: In fault, `gate_mode_o` is 1 and `ss_code_o` is 0, and over-current flags are ignored. After HICCUP_PERIODS (default 7) soft-start durations a fresh soft-start begins from code 0.
- R8: While over-voltage is flagged in soft-start or run, `gate_mode_o` is 1 and the reference code is kept. It returns to 2 when the flag clears.
- R9: While over-temperature is flagged in soft-start or run, `gate_mode_o` is 1. It returns to 2 when the flag clears.
- R10: Enable low or lockout overrides every other state, including fault. It clears the consecutive over-current count and the staircase, so the next start is a fresh soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_ok_i | input | 1 | Enable pin above its shutdown threshold |
| sup_low_i | input | 1 | Internal supply below the lockout-entry threshold |
| sup_high_i | input | 1 | Internal supply above the lockout-release threshold |
| oc_i | input | 1 | Low-side on-voltage beyond the current limit |
| ov_i | input | 1 | Output above the over-voltage trip point |
| ot_i | input | 1 | Die temperature above the thermal limit |
| cyc_tick_i | input | 1 | One-clock pulse per switching cycle |
| gate_mode_o | output | 2 | Driver mode: 0 off, 1 low side, 2 PWM |
| ss_code_o | output | CODE_W | Soft-start reference code |

## Verification
The bench sets the supply between the two thresholds. A design without hysteresis would then release or assert lockout at the wrong moment. It sends runs of six over-current ticks, with and without a single clean tick between them. A counter that fails to clear, or counts one tick too few, would latch a fault there. It also sends seven-tick runs, where a counter that counts one tick too many would miss the fault. The fault duration is sampled just before and after the expected restart, with an over-current burst inside the fault window. This catches a wrong period count and a fault timer that restarts on over-current. Two further cases apply over-current through a whole soft-start and drop enable in the middle of a fault. A design that fails to mask over-current during soft-start, or to clear state on shutdown, would latch a fault or resume it instead of ramping.

// File: rtl/cvt_seq_pkg.sv
// Shared encodings for the converter sequencing controller.
// Assumes: driver mode values are decoded by the gate-driver stage as-is.
package cvt_seq_pkg;

    typedef enum logic [1:0] {
        GATE_OFF = 2'd0,
        GATE_LOW = 2'd1,
        GATE_PWM = 2'd2
    } gate_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SOFT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cvt_flag_sync.sv
// Multi-stage synchroniser for a vector of independent comparator flags.
// Assumes: each bit is a level that changes slowly relative to clk; bits are
// not required to arrive together.
module cvt_flag_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw flags.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cvt_ss_stair.sv
// Soft-start staircase: a prescaler and a step counter that saturates at the
// all-ones code. Emits a one-clock done pulse when full scale is reached.
// Assumes: clr_i has priority over run_i; PRESC >= 2.
module cvt_ss_stair #(
    parameter int CODE_W = 6,
    parameter int PRESC  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);

    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0]     PLAST = PW'(PRESC - 1);
    localparam logic [CODE_W-1:0] FULL  = '1;

    logic [PW-1:0]     presc_q;
    logic [CODE_W-1:0] step_q;
    logic              done_q;
    logic              hit;

    assign hit = (presc_q == PLAST);

    // Advance the prescaler and step the code once per prescaled interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            presc_q <= '0;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else if (run_i) begin
            done_q <= hit && (step_q == FULL - 1'b1);
            if (hit) begin
                presc_q <= '0;
                if (step_q != FULL) step_q <= step_q + 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign code_o = step_q;
    assign done_o = done_q;

    // The staircase never steps backwards while it runs uncleared.
    assert_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i) |=> (step_q >= $past(step_q)));

    // A done pulse only appears with the code at full scale.
    assert_done_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (step_q == FULL));

endmodule

// File: rtl/cvt_oc_tracker.sv
// Per-switching-cycle over-current handling: a one-cycle low-side force and a
// consecutive-cycle counter that reports a trip on the LIMIT-th bad cycle.
// Assumes: oc_i is already synchronised; tick_i is a one-clock pulse.
module cvt_oc_tracker #(
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic oc_i,
    input  logic watch_i,
    input  logic arm_i,
    output logic force_o,
    output logic trip_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          force_q;

    // Count consecutive bad ticks while armed; any clean tick restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i)    cnt_q <= '0;
        else if (tick_i) begin
            if (!oc_i)           cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hold the low-side force from one tick to the next.
    always_ff @(posedge clk) begin
        if (!rst_n || !watch_i) force_q <= 1'b0;
        else if (tick_i)        force_q <= oc_i;
    end

    assign force_o = force_q;
    assign trip_o  = arm_i && tick_i && oc_i && (cnt_q == LAST);

    // The count stays below the trip limit.
    assert_cnt_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // Leaving the armed state clears the count.
    assert_disarm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (cnt_q == '0));

endmodule

// File: rtl/cvt_seq_ctrl.sv
// Converter protection sequencer. Walks off / soft-start / run / hiccup fault
// and overlays over-voltage, over-temperature and per-cycle over-current
// steering onto the driver mode.
// Assumes: all flags are asynchronous levels; cyc_tick_i is synchronous.
module cvt_seq_ctrl #(
    parameter int CODE_W         = 6,
    parameter int PRESC          = 1000,
    parameter int OC_LIMIT       = 7,
    parameter int HICCUP_PERIODS = 7,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_ok_i,
    input  logic              sup_low_i,
    input  logic              sup_high_i,
    input  logic              oc_i,
    input  logic              ov_i,
    input  logic              ot_i,
    input  logic              cyc_tick_i,
    output logic [1:0]        gate_mode_o,
    output logic [CODE_W-1:0] ss_code_o
);
    import cvt_seq_pkg::*;

    localparam int HW = $clog2(HICCUP_PERIODS + 1);
    localparam logic [HW-1:0]     HLAST = HW'(HICCUP_PERIODS - 1);
    localparam logic [CODE_W-1:0] FULL  = '1;

    logic [5:0]  flags_s;
    logic        en_s, sup_low_s, sup_high_s, oc_s, ov_s, ot_s;
    logic        uv_lock_q;
    logic        off_req;
    seq_state_e  state_q, state_n;
    logic [HW-1:0] hic_q;
    logic        st_run, st_clr, ss_done;
    logic [CODE_W-1:0] st_code;
    logic        oc_force, oc_trip;

    cvt_flag_sync #(.WIDTH(6), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({en_ok_i, sup_low_i, sup_high_i, oc_i, ov_i, ot_i}),
        .q_o   (flags_s)
    );
    assign {en_s, sup_low_s, sup_high_s, oc_s, ov_s, ot_s} = flags_s;

    // Lockout latch: set below the low threshold, released above the high one.
    always_ff @(posedge clk) begin
        if (!rst_n)          uv_lock_q <= 1'b1;
        else if (sup_low_s)  uv_lock_q <= 1'b1;
        else if (sup_high_s) uv_lock_q <= 1'b0;
    end

    assign off_req = !en_s || uv_lock_q;

    // Next-state selection; shutdown and lockout win over everything.
    always_comb begin
        state_n = state_q;
        if (off_req) begin
            state_n = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:   state_n = ST_SOFT;
                ST_SOFT:  if (ss_done) state_n = ST_RUN;
                ST_RUN:   if (oc_trip) state_n = ST_FAULT;
                ST_FAULT: if (ss_done && hic_q == HLAST) state_n = ST_SOFT;
                default:  state_n = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_n;
    end

    // Count completed staircase periods while the fault holds.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_FAULT) hic_q <= '0;
        else if (ss_done)                  hic_q <= (hic_q == HLAST) ? '0 : hic_q + 1'b1;
    end

    assign st_run = (state_q == ST_SOFT) || (state_q == ST_FAULT);
    assign st_clr = (state_q == ST_OFF) || (state_q == ST_RUN) ||
                    ((state_q == ST_FAULT) && ss_done);

    cvt_ss_stair #(.CODE_W(CODE_W), .PRESC(PRESC)) u_stair (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_run),
        .clr_i  (st_clr),
        .code_o (st_code),
        .done_o (ss_done)
    );

    cvt_oc_tracker #(.LIMIT(OC_LIMIT)) u_oc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (cyc_tick_i),
        .oc_i    (oc_s),
        .watch_i ((state_q == ST_SOFT) || (state_q == ST_RUN)),
        .arm_i   (state_q == ST_RUN),
        .force_o (oc_force),
        .trip_o  (oc_trip)
    );

    // Driver mode and reference code from the state and the overlays.
    always_comb begin
        case (state_q)
            ST_OFF:   gate_mode_o = GATE_OFF;
            ST_FAULT: gate_mode_o = GATE_LOW;
            default:  gate_mode_o = (ov_s || ot_s || oc_force) ? GATE_LOW : GATE_PWM;
        endcase
        case (state_q)
            ST_SOFT: ss_code_o = st_code;
            ST_RUN:  ss_code_o = FULL;
            default: ss_code_o = '0;
        endcase
    end

    // Enable low drives the outputs off on the following cycle.
    assert_off_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (gate_mode_o == GATE_OFF && ss_code_o == '0));

    // Mode value 3 never appears.
    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gate_mode_o != 2'd3);

    // Between the thresholds the lockout holds its value.
    assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_low_s && !sup_high_s) |=> $stable(uv_lock_q));

    // Soft-start never proceeds straight into a fault.
    assert_softstart_no_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFT) |=> (state_q != ST_FAULT));

    // Over-voltage keeps the high side off.
    assert_ov_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ov_s |-> (gate_mode_o != GATE_PWM));

    // Over-temperature keeps the high side off.
    assert_ot_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ot_s |-> (gate_mode_o != GATE_PWM));

endmodule

// File: tb/cvt_seq_ctrl_tb.sv
`timescale 1ns/1ps
module cvt_seq_ctrl_tb;

    localparam int CODE_W = 3;
    localparam int PRESC  = 8;
    localparam int FULLC  = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, lo = 1'b1, hi = 1'b0, oc = 1'b0, ov = 1'b0, ot = 1'b0;
    logic tick = 1'b0;
    logic [1:0] gate_mode;
    logic [CODE_W-1:0] ss_code;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cvt_seq_ctrl #(.CODE_W(CODE_W), .PRESC(PRESC), .OC_LIMIT(7),
                   .HICCUP_PERIODS(7), .SYNC_STAGES(2)) u_dut (
        .clk (clk), .rst_n (rst_n), .en_ok_i (en), .sup_low_i (lo),
        .sup_high_i (hi), .oc_i (oc), .ov_i (ov), .ot_i (ot),
        .cyc_tick_i (tick), .gate_mode_o (gate_mode), .ss_code_o (ss_code)
    );

    // Switching-cycle tick: one clock high in every four.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // Code classes: 0 zero, 1 mid-ramp, 2 full scale.
    function automatic string cls_name(input int c);
        return (c == 0) ? "zero" : (c == 1) ? "ramp" : "full";
    endfunction

    task automatic chk(input string req, input logic [1:0] eg, input int cls);
        logic ok;
        checks++;
        ok = (gate_mode == eg);
        if (cls == 0) ok = ok && (ss_code == 0);
        if (cls == 1) ok = ok && (ss_code > 0) && (ss_code < FULLC);
        if (cls == 2) ok = ok && (ss_code == FULLC);
        if (!ok) begin
            errors++;
            $display("FAIL %s actual gate=%0d code=%0d expected gate=%0d code=%s",
                     req, gate_mode, ss_code, eg, cls_name(cls));
        end
    endtask

    // Hold over-current for exactly n sampled ticks, starting after a tick.
    task automatic oc_ticks(input int n);
        @(posedge clk);
        while (!tick) @(posedge clk);
        @(negedge clk);
        oc = 1'b1;
        repeat (4 * n) @(negedge clk);
        oc = 1'b0;
    endtask

    // Vector: {en,lo,hi,ov,ot}[20:16], wait[15:8], gate[7:6], class[5:4], req[3:0]
    localparam logic [20:0] TBL [16] = '{
        {5'b01000, 8'd10, 2'd0, 2'd0, 4'd1},  // R1 disabled, supply low
        {5'b10000, 8'd10, 2'd0, 2'd0, 4'd2},  // R2 mid supply keeps lockout
        {5'b10100, 8'd70, 2'd2, 2'd2, 4'd3},  // R3 ramp completes
        {5'b10000, 8'd10, 2'd2, 2'd2, 4'd2},  // R2 mid supply keeps running
        {5'b10010, 8'd6,  2'd1, 2'd2, 4'd8},  // R8 over-voltage
        {5'b10000, 8'd6,  2'd2, 2'd2, 4'd8},  // R8 release
        {5'b10001, 8'd6,  2'd1, 2'd2, 4'd9},  // R9 over-temperature
        {5'b10000, 8'd6,  2'd2, 2'd2, 4'd9},  // R9 release
        {5'b11000, 8'd6,  2'd0, 2'd0, 4'd2},  // R2 lockout entry
        {5'b10000, 8'd20, 2'd0, 2'd0, 4'd2},  // R2 mid supply stays locked
        {5'b10100, 8'd30, 2'd2, 2'd1, 4'd3},  // R3 mid ramp
        {5'b10100, 8'd40, 2'd2, 2'd2, 4'd3},  // R3 full scale
        {5'b00100, 8'd6,  2'd0, 2'd0, 4'd1},  // R1 disable from run
        {5'b10100, 8'd70, 2'd2, 2'd2, 4'd3},  // R3 restart
        {5'b10111, 8'd6,  2'd1, 2'd2, 4'd9},  // R9 both flags
        {5'b10100, 8'd6,  2'd2, 2'd2, 4'd8}   // R8 release both
    };

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset", 2'd0, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++) begin
            {en, lo, hi, ov, ot} = TBL[i][20:16];
            repeat (int'(TBL[i][15:8])) @(negedge clk);
            chk($sformatf("R%0d vec%0d", TBL[i][3:0], i), TBL[i][7:6], int'(TBL[i][5:4]));
        end

        // R5: one bad tick forces the low side until the next tick.
        @(posedge clk);
        while (!tick) @(posedge clk);
        @(negedge clk);
        oc = 1'b1;
        repeat (4) @(negedge clk);
        oc = 1'b0;
        @(negedge clk);
        chk("R5 forced cycle", 2'd1, 2);
        repeat (4) @(negedge clk);
        chk("R5 next clean cycle", 2'd2, 2);

        // R6: six bad ticks, then six more after one clean tick: no fault.
        oc_ticks(6);
        repeat (10) @(negedge clk);
        chk("R6 six ticks", 2'd2, 2);
        oc_ticks(6);
        oc_ticks(6);
        repeat (10) @(negedge clk);
        chk("R6 count cleared", 2'd2, 2);

        // R6/R7: seven bad ticks latch a fault that ignores further flags.
        oc_ticks(7);
        repeat (10) @(negedge clk);
        chk("R6 fault latched", 2'd1, 0);
        repeat (90) @(negedge clk);
        oc = 1'b1;
        repeat (100) @(negedge clk);
        oc = 1'b0;
        repeat (180) @(negedge clk);
        chk("R7 still in fault", 2'd1, 0);
        repeat (39) @(negedge clk);
        chk("R7 fresh soft-start", 2'd2, 1);
        repeat (60) @(negedge clk);
        chk("R7 back to run", 2'd2, 2);

        // R4: over-current through a soft-start only steers cycles.
        en = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 shutdown", 2'd0, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        oc_ticks(9);
        chk("R4 forced during ramp", 2'd1, 1);
        repeat (40) @(negedge clk);
        chk("R4 no fault after ramp", 2'd2, 2);

        // R10: shutdown clears the consecutive count.
        oc_ticks(6);
        en = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 off", 2'd0, 0);
        en = 1'b1;
        repeat (70) @(negedge clk);
        oc_ticks(1);
        repeat (10) @(negedge clk);
        chk("R10 count cleared", 2'd2, 2);

        // R10: shutdown overrides a fault and restarts with a ramp.
        oc_ticks(7);
        repeat (10) @(negedge clk);
        chk("R6 fault again", 2'd1, 0);
        en = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 off over fault", 2'd0, 0);
        en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R10 fresh ramp", 2'd2, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule